// File: doc/BRIEF.md
# Oscillator Start-Up Delay Sequencer

This block keeps the system clock gated after a reset or a wake-up until the oscillator has had time to settle. Two kinds of event start a sequence. A wake from a sleep mode waits only a short, fixed number of oscillator cycles. Leaving reset waits a longer fixed number of oscillator cycles, then an optional extra delay measured in milliseconds. A 2-bit start-up select code chooses the length of that extra delay.

The millisecond part is counted from an external `ms_tick` pulse, so its length does not depend on the oscillator frequency. That count only begins once the cycle part is over. The select code is captured at the edge that starts a sequence and is held until the next start. The reserved code raises `cfg_error`, and the block then falls back to the longest delay.

Top module: `osc_startup_seq`

## Requirements
- R1: While `rst` is high and throughout every sequence, `clk_en` is 0. `rst` is a synchronous, active-high event that starts a reset sequence at each clock edge where it is sampled high.
- R2: With select code 2'b00 sampled at reset, `clk_en` goes to 1 at exactly the RESET_CYCLES-th rising edge after the last edge where `rst` was high.
- R3: With code 2'b01, the RESET_CYCLES cycle phase is followed by a phase that counts MS_SHORT `ms_tick` pulses. `clk_en` goes to 1 at the edge that samples the last of those pulses.
- R4: With code 2'b10, the sequence is the same as R3 but waits for MS_LONG pulses. This is the longest setting.
- R5: With reserved code 2'b11, `cfg_error` is 1 for the whole sequence and the delay matches code 2'b10. For every other code, `cfg_error` is 0.
- R6: An `ms_tick` pulse sampled at any of the first RESET_CYCLES edges after a reset start is ignored. It does not shorten the millisecond phase.
- R7: A `wake` pulse (with `rst` low) starts a wake sequence. `clk_en` goes to 1 at exactly the WAKE_CYCLES-th edge after it, whatever the select code is, and `ms_tick` has no effect.
- R8: A `rst` or `wake` event during a sequence restarts the count from the new event. The sequence takes the kind of the new event, and `rst` has priority over `wake`.
- R9: `sut_code` is sampled only at the start edge. A change during a sequence alters neither the delay nor `cfg_error`.
- R10: Once `clk_en` is 1, it stays 1 until the next `rst` or `wake` event, and `cfg_error` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset event; starts a reset sequence |
| wake | input | 1 | One-cycle wake-from-sleep event; starts a wake sequence |
| sut_code | input | 2 | Start-up select code, sampled at each sequence start |
| ms_tick | input | 1 | One-cycle millisecond time-base pulse |
| clk_en | output | 1 | Clock enable / ready flag, high once the sequence completes |
| cfg_error | output | 1 | High when the sampled select code is the reserved value |

## Verification
The bench builds the block with WAKE_CYCLES=6 and RESET_CYCLES=14, but with MS_SHORT=2 and MS_LONG=5, so every select code runs to completion in a few dozen cycles. That makes a full sweep of all four codes affordable under several tick spacings, including a tick on every edge. A tick on every edge is the pattern that exposes ticks leaking into the cycle phase. The small counts also leave room for directed restarts, mid-sequence code changes and wake runs, each with an exact expected completion edge that the bench computes arithmetically.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

    typedef enum logic [1:0] {
        PH_CYC  = 2'd0,
        PH_MS   = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_FAST = 2'b01,
        SEL_SLOW = 2'b10,
        SEL_RSVD = 2'b11
    } start_sel_e;

    typedef struct packed {
        phase_e     phase;
        logic       from_wake;
        start_sel_e sel;
    } seq_state_t;

    // Extra millisecond count for a reset sequence; reserved falls back to the long delay.
    function automatic int unsigned ms_delay(start_sel_e sel, int unsigned short_ms,
                                             int unsigned long_ms);
        case (sel)
            SEL_NONE: return 0;
            SEL_FAST: return short_ms;
            default:  return long_ms;
        endcase
    endfunction

    function automatic logic sel_reserved(start_sel_e sel);
        return sel == SEL_RSVD;
    endfunction

endpackage

// File: rtl/osc_cycle_timer.sv
module osc_cycle_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign done = run && (cnt_q == limit - W'(1));
endmodule

// File: rtl/osc_ms_timer.sv
module osc_ms_timer #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign done = run && tick && (cnt_q == target - W'(1));
endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
    import osc_startup_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES  = 6,
    parameter int unsigned RESET_CYCLES = 14,
    parameter int unsigned MS_SHORT     = 4,
    parameter int unsigned MS_LONG      = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake,
    input  logic [1:0] sut_code,
    input  logic       ms_tick,
    output logic       clk_en,
    output logic       cfg_error
);
    localparam int unsigned CYC_MAX = (RESET_CYCLES > WAKE_CYCLES) ? RESET_CYCLES : WAKE_CYCLES;
    localparam int unsigned MS_MAX  = (MS_LONG > MS_SHORT) ? MS_LONG : MS_SHORT;
    localparam int unsigned CW      = $clog2(CYC_MAX + 1);
    localparam int unsigned MW      = $clog2(MS_MAX + 1);

    seq_state_t    st_q;
    logic          start;
    logic          cyc_done;
    logic          ms_done;
    logic [CW-1:0] cyc_limit;
    logic [MW-1:0] ms_target;

    assign start     = rst || wake;
    assign cyc_limit = st_q.from_wake ? CW'(WAKE_CYCLES) : CW'(RESET_CYCLES);
    assign ms_target = MW'(ms_delay(st_q.sel, MS_SHORT, MS_LONG));

    osc_cycle_timer #(.W(CW)) u_cyc (
        .clk   (clk),
        .clear (start),
        .run   (st_q.phase == PH_CYC),
        .limit (cyc_limit),
        .done  (cyc_done)
    );

    osc_ms_timer #(.W(MW)) u_ms (
        .clk    (clk),
        .clear  (start),
        .run    (st_q.phase == PH_MS),
        .tick   (ms_tick),
        .target (ms_target),
        .done   (ms_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_CYC, from_wake: 1'b0, sel: start_sel_e'(sut_code)};
        end else if (wake) begin
            st_q <= '{phase: PH_CYC, from_wake: 1'b1, sel: start_sel_e'(sut_code)};
        end else begin
            case (st_q.phase)
                PH_CYC: if (cyc_done) begin
                    st_q.phase <= (st_q.from_wake || ms_target == '0) ? PH_DONE : PH_MS;
                end
                PH_MS: if (ms_done) begin
                    st_q.phase <= PH_DONE;
                end
                default: st_q.phase <= PH_DONE;
            endcase
        end
    end

    assign clk_en    = (st_q.phase == PH_DONE);
    assign cfg_error = sel_reserved(st_q.sel);
endmodule

// File: rtl/osc_startup_seq_chk.sv
module osc_startup_seq_chk #(
    parameter int unsigned WAKE_CYCLES  = 6,
    parameter int unsigned RESET_CYCLES = 14
) (
    input logic       clk,
    input logic       rst,
    input logic       wake,
    input logic [1:0] sut_code,
    input logic       ms_tick,
    input logic       clk_en,
    input logic       cfg_error
);
    logic armed = 1'b0;
    logic last_wake = 1'b0;
    int   seq_len = 0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
        if (rst || wake) begin
            seq_len   <= 0;
            last_wake <= !rst;
        end else if (!clk_en) begin
            seq_len <= seq_len + 1;
        end
    end

    // R1, R8: any start event drops the enable on the next cycle
    p_start_gates_r1: assert property (@(posedge clk) disable iff (!armed)
        (rst || wake) |=> !clk_en);

    // R10: the enable holds without a new event
    p_ready_holds_r10: assert property (@(posedge clk) disable iff (!armed)
        (clk_en && !rst && !wake) |=> clk_en);

    // R5: error flag follows the code captured at reset
    p_err_sampled_r5: assert property (@(posedge clk) disable iff (!armed)
        rst |=> (cfg_error == ($past(sut_code) == 2'b11)));

    // R9: error flag does not move inside a sequence
    p_err_held_r9: assert property (@(posedge clk) disable iff (!armed)
        (!rst && !wake) |=> $stable(cfg_error));

    // R7: wake sequences last exactly WAKE_CYCLES edges
    p_wake_len_r7: assert property (@(posedge clk) disable iff (!armed)
        ($rose(clk_en) && last_wake) |-> (seq_len == WAKE_CYCLES));

    // R2, R6: reset sequences never finish before RESET_CYCLES edges
    p_reset_min_r2: assert property (@(posedge clk) disable iff (!armed)
        ($rose(clk_en) && !last_wake) |-> (seq_len >= RESET_CYCLES));

    // unused-input sink for the tick line
    logic tick_seen;
    assign tick_seen = ms_tick;
endmodule

bind osc_startup_seq osc_startup_seq_chk #(
    .WAKE_CYCLES  (WAKE_CYCLES),
    .RESET_CYCLES (RESET_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wake      (wake),
    .sut_code  (sut_code),
    .ms_tick   (ms_tick),
    .clk_en    (clk_en),
    .cfg_error (cfg_error)
);

// File: tb/osc_startup_seq_tb.sv
module osc_startup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE_C  = 6;
    localparam int RESET_C = 14;
    localparam int MS_S    = 2;
    localparam int MS_L    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake = 1'b0;
    logic [1:0] sut_code = 2'b00;
    logic       ms_tick = 1'b0;
    logic       clk_en;
    logic       cfg_error;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    osc_startup_seq #(
        .WAKE_CYCLES  (WAKE_C),
        .RESET_CYCLES (RESET_C),
        .MS_SHORT     (MS_S),
        .MS_LONG      (MS_L)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wake      (wake),
        .sut_code  (sut_code),
        .ms_tick   (ms_tick),
        .clk_en    (clk_en),
        .cfg_error (cfg_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // poke_kind: 0 none, 1 change sut_code, 2 rst restart, 3 wake restart
    task automatic run_seq(input logic [1:0] code, input bit use_wake, input int gap,
                           input int poke_at, input int poke_kind,
                           input logic [1:0] poke_code, input string req);
        int start_e;
        int exp_e;
        int tgt;
        int n;
        int first_hi;
        bit kind_wake;
        bit dropped;
        start_e   = (poke_kind >= 2) ? poke_at : 0;
        kind_wake = (poke_kind == 3) ? 1'b1 : ((poke_kind == 2) ? 1'b0 : use_wake);
        tgt = (code == 2'b00) ? 0 : ((code == 2'b01) ? MS_S : MS_L);
        exp_e = -1;
        if (kind_wake) begin
            exp_e = start_e + WAKE_C;
        end else if (tgt == 0) begin
            exp_e = start_e + RESET_C;
        end else begin
            n = 0;
            for (int e = start_e + RESET_C + 1; exp_e < 0; e++) begin
                if ((e % gap) == gap - 1) n++;
                if (n == tgt) exp_e = e;
            end
        end
        @(negedge clk);
        sut_code = code;
        ms_tick  = 1'b0;
        if (use_wake) wake = 1'b1; else rst = 1'b1;
        first_hi = -1;
        dropped  = 1'b0;
        for (int i = 1; i <= exp_e + 5; i++) begin
            @(negedge clk);
            if (first_hi < 0 && clk_en) first_hi = i - 1;
            if (first_hi >= 0 && !clk_en) dropped = 1'b1;
            rst     = 1'b0;
            wake    = 1'b0;
            ms_tick = ((i % gap) == gap - 1);
            if (i == poke_at) begin
                case (poke_kind)
                    1: sut_code = poke_code;
                    2: rst = 1'b1;
                    3: wake = 1'b1;
                    default: ;
                endcase
            end
        end
        check(first_hi == exp_e, req, first_hi, exp_e);
        check(!dropped, "R10 enable held", int'(dropped), 0);
        check(cfg_error == (code == 2'b11), {req, " cfg_error (R5)"}, int'(cfg_error),
              int'(code == 2'b11));
        ms_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(clk_en == 1'b0, "R1 reset enable", int'(clk_en), 0);
        check(cfg_error == 1'b0, "R1 reset error", int'(cfg_error), 0);
        // sweep codes and tick spacings for reset sequences (R2..R6)
        for (int c = 0; c < 4; c++) begin
            for (int g = 1; g <= 3; g++) begin
                case (c)
                    0: run_seq(2'(c), 1'b0, g, 0, 0, 2'b00, "R2 code00");
                    1: run_seq(2'(c), 1'b0, g, 0, 0, 2'b00, "R3/R6 code01");
                    2: run_seq(2'(c), 1'b0, g, 0, 0, 2'b00, "R4/R6 code10");
                    default: run_seq(2'(c), 1'b0, g, 0, 0, 2'b00, "R5/R6 code11");
                endcase
            end
        end
        // wake sequences, every code, ticks on every edge (R7)
        for (int c = 0; c < 4; c++) begin
            run_seq(2'(c), 1'b1, 1, 0, 0, 2'b00, "R7 wake");
        end
        // restarts (R8)
        run_seq(2'b00, 1'b0, 2, 7, 2, 2'b00, "R8 rst restart");
        run_seq(2'b10, 1'b0, 1, 10, 3, 2'b00, "R8 wake restart");
        run_seq(2'b01, 1'b1, 1, 3, 2, 2'b00, "R8 rst over wake");
        // mid-sequence code changes (R9)
        run_seq(2'b01, 1'b0, 2, 5, 1, 2'b00, "R9 code change");
        run_seq(2'b00, 1'b0, 1, 3, 1, 2'b11, "R9 code change to reserved");
        run_seq(2'b11, 1'b0, 1, 16, 1, 2'b00, "R9 change in ms phase");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule